// File: doc/BRIEF.md
# Strap latch and clock mode controller

This block sits beside the clock synthesizers of a board-level clock generator and decides what every output group does. At power-on it samples four dual-purpose pins as configuration straps: two frequency selects and two current-multiplier selects. It keeps those levels and then signals that the pins may be driven as clock outputs. A power-down and wake-up through the power-down input never reloads the straps; only a new power-on reset does.

From the two latched frequency selects and the live host-speed input it decodes one of four operating modes: 100 MHz host, 133 MHz host, all outputs high-impedance, and a test mode in which every group runs from a fixed division of the reference clock. Reserved select codes raise an error flag and fall back to the 100 MHz encoding. For each of the six output groups the block produces a drive enable, a high-impedance control and a clock-source code. It also gives the host current multiplier and three free-running reference dividers used in test mode. The live host-speed and power-down inputs pass through two synchronizer flops on the reference clock. The decode stage is registered.

Top module: `clkcfg_ctrl`

## Requirements
- R1: While `por` is high, `strap_drive_o`, `grp_en_o`, `grp_hiz_o` and `tclk_o` are all 0. `strap_drive_o` becomes 1 at the first rising edge after `por` falls. The latched straps equal the pin levels present during the last reset cycle.
- R2: Once `por` is low, changes on the strap pins have no effect on `mult_o` or on the decoded mode. This also holds across any number of power-down entries and exits.
- R3: `mult_o` gives the host current multiplier from the latched straps, written as {isel[0], isel[1]}: 00 gives 5, 01 gives 6, 10 gives 4, 11 gives 7.
- R4: The select code is {host_fast, fsel[0], fsel[1]}. Code 000 gives `mode_o`=0 (100 MHz) and code 100 gives `mode_o`=1 (133 MHz). With power-down inactive, both codes give `grp_en_o`=all ones and `grp_hiz_o`=0. Group bit order is 0 host, 1 memory reference, 2 66 MHz, 3 PCI, 4 48 MHz, 5 reference. In every mode except test, each group source field (3 bits per group at `grp_src_o[3g+:3]`) is 0 (synthesizer), except the reference group, which is 1 (crystal).
- R5: Code 011 gives `mode_o`=2, and with power-down inactive `grp_hiz_o`=all ones and `grp_en_o`=0.
- R6: Code 111 gives `mode_o`=3 and test sources: host and 48 MHz groups 2 (reference/2), memory-reference and 66 MHz groups 3 (reference/4), PCI group 4 (reference/8), and reference group 1 (crystal). Enables are all ones when power-down is inactive.
- R7: Codes 001, 010, 101 and 110 set `rsvd_err_o`=1 and give `mode_o`=0 with the 100 MHz enables and sources. All other codes give `rsvd_err_o`=0.
- R8: With `pwrdn_n` low, `grp_en_o`=0 and `grp_hiz_o`=0 for every code, which holds every single-ended group low and puts the host pairs in their power-down drive. `mode_o`, `rsvd_err_o` and `grp_src_o` still follow the code.
- R9: `tclk_o` is a counter reset to 0 by `por` that advances once per reference edge. Bits 0, 1 and 2 are reference/2, /4 and /8, each with 50 percent duty.
- R10: A change on `host_fast` or `pwrdn_n` reaches the decoded outputs at the third rising edge after it, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| strap_fsel | input | 2 | Frequency-select strap pins (bit 0 = select A, bit 1 = select B) |
| strap_isel | input | 2 | Current-multiplier strap pins |
| host_fast | input | 1 | Live host speed select (1 = 133 MHz) |
| pwrdn_n | input | 1 | Live power-down request, active low |
| mode_o | output | 2 | Decoded mode: 0 100 MHz, 1 133 MHz, 2 high-Z, 3 test |
| rsvd_err_o | output | 1 | Reserved select code seen |
| grp_en_o | output | 6 | Per-group drive enable |
| grp_hiz_o | output | 6 | Per-group high-impedance control |
| grp_src_o | output | 18 | Per-group clock-source code, 3 bits each |
| tclk_o | output | 3 | Reference /2, /4, /8 test clocks |
| mult_o | output | 3 | Host current multiplier (4 to 7) |
| strap_drive_o | output | 1 | Strap pins released to output duty |

## Verification
Power-down and the mode decode can act in the same cycle: a reserved, high-Z or test code can arrive together with a power-down request. Random pairs of host-speed and power-down values are applied on every latched strap, so that power-down meets every code. Each result is judged against a bench model in which power-down clears enables and high-Z controls while the mode, error flag and sources still follow the code. Strap-pin toggling is also mixed into the same windows to show that pins driven after reset never change the latched configuration.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  localparam int NGRP   = 6;
  localparam int SRC_W  = 3;
  localparam int MULT_W = 3;

  localparam int G_HOST = 0;
  localparam int G_MREF = 1;
  localparam int G_CK66 = 2;
  localparam int G_PCI  = 3;
  localparam int G_CK48 = 4;
  localparam int G_XREF = 5;

  typedef enum logic [1:0] {
    MODE_STD  = 2'd0,
    MODE_FAST = 2'd1,
    MODE_HIZ  = 2'd2,
    MODE_TEST = 2'd3
  } mode_e;

  typedef enum logic [SRC_W-1:0] {
    SRC_PLL  = 3'd0,
    SRC_XTAL = 3'd1,
    SRC_DIV2 = 3'd2,
    SRC_DIV4 = 3'd3,
    SRC_DIV8 = 3'd4
  } src_e;

  // Source of each group while the test mode is active
  function automatic src_e test_src(input int g);
    case (g)
      G_HOST, G_CK48: return SRC_DIV2;
      G_MREF, G_CK66: return SRC_DIV4;
      G_PCI:          return SRC_DIV8;
      default:        return SRC_XTAL;
    endcase
  endfunction

  // Source of each group in every other mode
  function automatic src_e norm_src(input int g);
    return (g == G_XREF) ? SRC_XTAL : SRC_PLL;
  endfunction

  // Multiplier from {isel[0], isel[1]}
  function automatic logic [MULT_W-1:0] mult_map(input logic [1:0] isel);
    case ({isel[0], isel[1]})
      2'b00:   return 3'd5;
      2'b01:   return 3'd6;
      2'b10:   return 3'd4;
      default: return 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/clkcfg_sync.sv
module clkcfg_sync #(
  parameter int          WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/clkcfg_strap.sv
module clkcfg_strap
  import clkcfg_pkg::*;
(
  input  logic              clk,
  input  logic              por,
  input  logic [1:0]        pin_fsel,
  input  logic [1:0]        pin_isel,
  output logic [1:0]        fsel_o,
  output logic [MULT_W-1:0] mult_o,
  output logic              drive_o
);

  logic [1:0]        fsel_q;
  logic [1:0]        isel_q;
  logic [MULT_W-1:0] mult_q;
  logic              drive_q;

  // Pins are inputs for as long as reset lasts; the last sample is kept
  always_ff @(posedge clk) begin
    if (por) begin
      fsel_q  <= pin_fsel;
      isel_q  <= pin_isel;
      drive_q <= 1'b0;
    end else begin
      drive_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    mult_q <= mult_map(isel_q);
  end

  assign fsel_o  = fsel_q;
  assign mult_o  = mult_q;
  assign drive_o = drive_q;

  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (por)
    drive_q |=> ($stable(fsel_q) && $stable(isel_q))) else $error("strap reloaded"); // R2

  AST_MULT_VALID: assert property (@(posedge clk) disable iff (por)
    drive_q |-> (mult_q >= 3'd4)) else $error("multiplier out of range"); // R3

endmodule

// File: rtl/clkcfg_divider.sv
module clkcfg_divider #(
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              por,
  output logic [STAGES-1:0] tclk_o
);

  logic [STAGES-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (por) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign tclk_o = cnt_q;

  AST_DIV2_TOGGLE: assert property (@(posedge clk) disable iff (por)
    1'b1 |=> (cnt_q[0] != $past(cnt_q[0]))) else $error("div2 stalled"); // R9

  AST_DIV_RESET: assert property (@(posedge clk)
    $past(por) |-> (cnt_q == '0)) else $error("divider not cleared"); // R9

endmodule

// File: rtl/clkcfg_decode.sv
module clkcfg_decode
  import clkcfg_pkg::*;
(
  input  logic                  clk,
  input  logic                  por,
  input  logic                  host_fast_s,
  input  logic                  pd_s,
  input  logic [1:0]            fsel,
  output logic [1:0]            mode_o,
  output logic                  err_o,
  output logic [NGRP-1:0]       en_o,
  output logic [NGRP-1:0]       hiz_o,
  output logic [NGRP*SRC_W-1:0] src_o
);

  mode_e            mode_d;
  logic             err_d;
  logic [2:0]       code;

  mode_e            mode_q;
  logic             err_q;
  logic [NGRP-1:0]  en_q;
  logic [NGRP-1:0]  hiz_q;

  assign code = {host_fast_s, fsel[0], fsel[1]};

  always_comb begin
    err_d = 1'b0;
    case (code)
      3'b000:  mode_d = MODE_STD;
      3'b100:  mode_d = MODE_FAST;
      3'b011:  mode_d = MODE_HIZ;
      3'b111:  mode_d = MODE_TEST;
      default: begin
        mode_d = MODE_STD;
        err_d  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (por) begin
      mode_q <= MODE_STD;
      err_q  <= 1'b0;
      en_q   <= '0;
      hiz_q  <= '0;
    end else begin
      mode_q <= mode_d;
      err_q  <= err_d;
      if (pd_s) begin
        en_q  <= '0;
        hiz_q <= '0;
      end else if (mode_d == MODE_HIZ) begin
        en_q  <= '0;
        hiz_q <= '1;
      end else begin
        en_q  <= '1;
        hiz_q <= '0;
      end
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_src
    localparam src_e TSRC = test_src(g);
    localparam src_e NSRC = norm_src(g);
    src_e src_q;

    always_ff @(posedge clk) begin
      if (por)                      src_q <= NSRC;
      else if (mode_d == MODE_TEST) src_q <= TSRC;
      else                          src_q <= NSRC;
    end

    assign src_o[g*SRC_W +: SRC_W] = src_q;
  end

  assign mode_o = mode_q;
  assign err_o  = err_q;
  assign en_o   = en_q;
  assign hiz_o  = hiz_q;

  AST_PD_QUIET: assert property (@(posedge clk) disable iff (por)
    pd_s |=> (en_q == '0 && hiz_q == '0)) else $error("outputs active in power-down"); // R8

  AST_HIZ_ALL: assert property (@(posedge clk) disable iff (por)
    (hiz_q != '0) |-> (hiz_q == '1 && en_q == '0 && mode_q == MODE_HIZ)) else $error("partial high-Z"); // R5

  AST_ERR_FALLBACK: assert property (@(posedge clk) disable iff (por)
    err_q |-> (mode_q == MODE_STD)) else $error("reserved code not folded"); // R7

  AST_TEST_PCI: assert property (@(posedge clk) disable iff (por)
    (mode_q == MODE_TEST) |-> (src_o[G_PCI*SRC_W +: SRC_W] == SRC_DIV8)) else $error("pci test source"); // R6

endmodule

// File: rtl/clkcfg_ctrl.sv
module clkcfg_ctrl
  import clkcfg_pkg::*;
#(
  parameter int DIV_STAGES = 3
) (
  input  logic                  ref_clk,
  input  logic                  por,
  input  logic [1:0]            strap_fsel,
  input  logic [1:0]            strap_isel,
  input  logic                  host_fast,
  input  logic                  pwrdn_n,
  output logic [1:0]            mode_o,
  output logic                  rsvd_err_o,
  output logic [NGRP-1:0]       grp_en_o,
  output logic [NGRP-1:0]       grp_hiz_o,
  output logic [NGRP*SRC_W-1:0] grp_src_o,
  output logic [DIV_STAGES-1:0] tclk_o,
  output logic [MULT_W-1:0]     mult_o,
  output logic                  strap_drive_o
);

  logic [1:0] fsel_l;
  logic [1:0] live_s;

  clkcfg_strap u_strap (
    .clk      (ref_clk),
    .por      (por),
    .pin_fsel (strap_fsel),
    .pin_isel (strap_isel),
    .fsel_o   (fsel_l),
    .mult_o   (mult_o),
    .drive_o  (strap_drive_o)
  );

  // bit 1: power-down request (reset asserted), bit 0: host speed
  clkcfg_sync #(.WIDTH(2), .RST_VAL(2'b10)) u_sync (
    .clk (ref_clk),
    .rst (por),
    .d   ({~pwrdn_n, host_fast}),
    .q   (live_s)
  );

  clkcfg_decode u_decode (
    .clk         (ref_clk),
    .por         (por),
    .host_fast_s (live_s[0]),
    .pd_s        (live_s[1]),
    .fsel        (fsel_l),
    .mode_o      (mode_o),
    .err_o       (rsvd_err_o),
    .en_o        (grp_en_o),
    .hiz_o       (grp_hiz_o),
    .src_o       (grp_src_o)
  );

  clkcfg_divider #(.STAGES(DIV_STAGES)) u_div (
    .clk    (ref_clk),
    .por    (por),
    .tclk_o (tclk_o)
  );

  AST_RESET_QUIET: assert property (@(posedge ref_clk)
    $past(por) |-> (grp_en_o == '0 && grp_hiz_o == '0)) else $error("active after reset"); // R1

endmodule

// File: tb/clkcfg_ctrl_test.sv
module clkcfg_ctrl_test;

  logic        clk = 1'b0;
  logic        por;
  logic [1:0]  fsel_pin, isel_pin;
  logic        hs, pdn;
  logic [1:0]  mode;
  logic        err;
  logic [5:0]  en, hiz;
  logic [17:0] src;
  logic [2:0]  tclk, mult;
  logic        drv;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  clkcfg_ctrl uut (
    .ref_clk(clk), .por(por), .strap_fsel(fsel_pin), .strap_isel(isel_pin),
    .host_fast(hs), .pwrdn_n(pdn), .mode_o(mode), .rsvd_err_o(err),
    .grp_en_o(en), .grp_hiz_o(hiz), .grp_src_o(src), .tclk_o(tclk),
    .mult_o(mult), .strap_drive_o(drv)
  );

  function automatic logic [2:0] f_mode(input logic [2:0] c);
    case (c)
      3'b000: return 3'd0;
      3'b100: return 3'd1;
      3'b011: return 3'd2;
      3'b111: return 3'd3;
      default: return 3'd4; // reserved marker
    endcase
  endfunction

  function automatic logic [17:0] f_src(input logic [1:0] m);
    logic [17:0] v;
    int tsrc [6] = '{2, 3, 3, 4, 2, 1};
    for (int g = 0; g < 6; g++)
      v[g*3 +: 3] = (m == 2'd3) ? 3'(tsrc[g]) : ((g == 5) ? 3'd1 : 3'd0);
    return v;
  endfunction

  function automatic logic [2:0] f_mult(input logic [1:0] is);
    case ({is[0], is[1]})
      2'b00: return 3'd5;
      2'b01: return 3'd6;
      2'b10: return 3'd4;
      default: return 3'd7;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // Full check of decoded outputs for live inputs and latched frequency straps
  task automatic chk_all(input string req, input logic h, input logic p_n, input logic [1:0] fs);
    logic [2:0] m;
    logic [1:0] me;
    m  = f_mode({h, fs[0], fs[1]});
    me = (m == 3'd4) ? 2'd0 : m[1:0];
    chk(req, "mode", 32'(mode), 32'(me));
    chk(req, "err", 32'(err), 32'(m == 3'd4));
    chk(req, "src", 32'(src), 32'(f_src(me)));
    if (!p_n) begin
      chk(req, "en", 32'(en), 32'h0);
      chk(req, "hiz", 32'(hiz), 32'h0);
    end else if (me == 2'd2) begin
      chk(req, "en", 32'(en), 32'h0);
      chk(req, "hiz", 32'(hiz), 32'h3f);
    end else begin
      chk(req, "en", 32'(en), 32'h3f);
      chk(req, "hiz", 32'(hiz), 32'h0);
    end
  endtask

  task automatic apply(input logic h, input logic p_n);
    @(negedge clk);
    hs  = h;
    pdn = p_n;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic power_on(input logic [1:0] fs, input logic [1:0] is);
    @(negedge clk);
    fsel_pin = fs;
    isel_pin = is;
    por      = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", "drive in reset", 32'(drv), 32'h0);
    chk("R1", "en in reset", 32'(en), 32'h0);
    chk("R1", "hiz in reset", 32'(hiz), 32'h0);
    chk("R1", "tclk in reset", 32'(tclk), 32'h0);
    por = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    por = 1'b1; fsel_pin = 2'b00; isel_pin = 2'b00; hs = 1'b0; pdn = 1'b1;

    for (int s = 0; s < 4; s++) begin
      logic [1:0] fs, is;
      fs = 2'(s);
      is = 2'(3 - s);
      power_on(fs, is);
      if (s == 0) begin
        // R9: divider phase counted from release of reset
        for (int k = 0; k < 16; k++) begin
          chk("R9", "tclk phase", 32'(tclk), 32'(k % 8));
          if (k == 1) chk("R1", "drive after reset", 32'(drv), 32'h1);
          @(posedge clk);
          @(negedge clk);
        end
      end else begin
        @(posedge clk);
        @(negedge clk);
        chk("R1", "drive after reset", 32'(drv), 32'h1);
      end
      // pins now carry clocks: scramble them
      fsel_pin = ~fs;
      isel_pin = ~is;
      chk("R3", "multiplier", 32'(mult), 32'(f_mult(is)));

      apply(1'b0, 1'b1);
      chk_all((s == 0) ? "R4" : (s == 3) ? "R5" : "R7", 1'b0, 1'b1, fs);
      apply(1'b1, 1'b1);
      chk_all((s == 0) ? "R4" : (s == 3) ? "R6" : "R7", 1'b1, 1'b1, fs);

      if (s == 0) begin
        // R10: host speed change lands on the third edge
        @(negedge clk);
        hs = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R10", "mode before third edge", 32'(mode), 32'h1);
        @(posedge clk);
        @(negedge clk);
        chk("R10", "mode at third edge", 32'(mode), 32'h0);
      end

      apply(hs, 1'b0);
      chk_all("R8", hs, 1'b0, fs);

      // R2: strap pins toggled through power-down exits
      for (int r = 0; r < 30; r++) begin
        logic h, p;
        h = 1'($urandom_range(0, 1));
        p = 1'($urandom_range(0, 3) != 0);
        fsel_pin = 2'($urandom_range(0, 3));
        isel_pin = 2'($urandom_range(0, 3));
        apply(h, p);
        chk_all(p ? "R2" : "R8", h, p, fs);
        chk("R2", "multiplier held", 32'(mult), 32'(f_mult(is)));
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule